// File: doc/BRIEF.md
# Trap CSR Bank with Supervisor Views

This block holds the control and status registers that a privileged processor core uses for trap handling at two privilege levels. The supervisor-level status, interrupt-enable and interrupt-pending registers have no storage of their own. Each one is a filtered window onto the matching machine-level register, so a supervisor write can only touch bits that machine software has exposed. For the interrupt registers, the exposed bits are the ones set in the delegation register.

The core reaches the bank through one 32-bit port. It presents a 12-bit CSR address, reads the addressed register combinationally on `csr_rdata`, and commits a write on the rising clock edge when `csr_wr_en` is high. Read-modify-write operations are composed outside the block. Besides the status and interrupt registers, the bank holds two scratch registers and two exception-return PCs, and it has a trigger-select register whose readback shows that no trigger is present. Platform interrupt sources drive `hw_pending`, and their bits are merged into the pending register. An address the bank does not implement reads as zero and takes no write.

Top module: `trap_csr_bank`

## Requirements
- R1: After reset every implemented register reads zero, with one exception: the trigger-select address 0x7A0 reads 32'hFFFF_FFFF.
- R2: A write to machine status 0x300 keeps only bits 1, 3, 5, 7, 8, 11, 12, 18 and 19 and clears all others. If the written value has bits [12:11] equal to 2'b10, bits [12:11] keep their previous value instead.
- R3: Supervisor status 0x100 reads machine status ANDed with 32'h000C_0122, which is bits 1, 5, 8, 18 and 19. A write to 0x100 changes only those bits of machine status, and every other bit keeps its value.
- R4: The delegation register 0x303 stores only bits 1, 5 and 9 of a write. All other bits read zero.
- R5: Machine interrupt-enable 0x304 stores bits 1, 3, 5, 7, 9 and 11 of a write. Supervisor enable 0x104 reads 0x304 ANDed with 0x303. A write to 0x104 changes only the bits of 0x304 that are set in 0x303.
- R6: Machine pending 0x344 reads the software-pending bits ORed with `hw_pending` masked to bits 1, 3, 5, 7, 9 and 11. A write to 0x344 stores only bits 1, 5 and 9 into the software-pending bits. A bit driven high by `hw_pending` reads one whatever software writes.
- R7: Supervisor pending 0x144 reads the 0x344 value ANDed with 0x303. A write to 0x144 changes only software-pending bits that are set in 0x303.
- R8: Scratch registers 0x340 and 0x140 store and return all 32 bits unchanged.
- R9: Exception-return PCs 0x341 and 0x141 store all 32 bits. A read clears bit 0 when `compressed_en` is 1, and clears bits 1 and 0 when `compressed_en` is 0.
- R10: Trigger-select 0x7A0 stores a write, and a read returns the bitwise complement of the stored value.
- R11: Any other address reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Write strobe for the addressed register |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write value |
| csr_rdata | output | 32 | Combinational read value of the addressed register |
| compressed_en | input | 1 | 1 when 16-bit instructions are enabled; selects the return-PC read mask |
| hw_pending | input | 32 | Interrupt-pending bits driven by platform sources |

## Verification
The bench walks single-bit, dense and zero patterns through every implemented address under four delegation settings. After each write it reads the whole bank back, so it catches a supervisor write that reaches an undelegated bit or a machine-only status bit, where a faulty design would silently change machine state. It writes bit 12 alone right after a value with both bits [12:11] set, to confirm that the reserved previous-mode code is refused; a faulty design would store the illegal 2'b10. It holds `hw_pending` high while software clears pending bits, where a faulty design would let the platform interrupt vanish. It reads all 4096 addresses so that any stray decode returns nonzero data. It also toggles `compressed_en` under a fixed return PC, where a faulty design would leak bit 1 or clear it at the wrong time.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

   localparam int unsigned CSR_AW = 12;

   // Address map: these codes are what software issues, so they are behaviour
   localparam logic [CSR_AW-1:0] A_MSTATUS  = 12'h300;
   localparam logic [CSR_AW-1:0] A_SSTATUS  = 12'h100;
   localparam logic [CSR_AW-1:0] A_MIDELEG  = 12'h303;
   localparam logic [CSR_AW-1:0] A_MIE      = 12'h304;
   localparam logic [CSR_AW-1:0] A_SIE      = 12'h104;
   localparam logic [CSR_AW-1:0] A_MIP      = 12'h344;
   localparam logic [CSR_AW-1:0] A_SIP      = 12'h144;
   localparam logic [CSR_AW-1:0] A_MSCRATCH = 12'h340;
   localparam logic [CSR_AW-1:0] A_SSCRATCH = 12'h140;
   localparam logic [CSR_AW-1:0] A_MEPC     = 12'h341;
   localparam logic [CSR_AW-1:0] A_SEPC     = 12'h141;
   localparam logic [CSR_AW-1:0] A_TSEL     = 12'h7A0;

   // Status word: legal bits and the supervisor window onto them
   localparam logic [31:0] STATUS_WMASK = 32'h000C_19AA;
   localparam logic [31:0] SSTATUS_VIEW = 32'h000C_0122;
   localparam int unsigned MPP_LSB      = 11;
   localparam logic [1:0]  MPP_RESERVED = 2'b10;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_MSTATUS,
      SEL_SSTATUS,
      SEL_MIDELEG,
      SEL_MIE,
      SEL_SIE,
      SEL_MIP,
      SEL_SIP,
      SEL_MSCRATCH,
      SEL_SSCRATCH,
      SEL_MEPC,
      SEL_SEPC,
      SEL_TSEL
   } csr_sel_e;

   localparam int unsigned NSEL = 13;

   // Slots inside the plain storage bank
   localparam int unsigned PL_MSCR = 0;
   localparam int unsigned PL_SSCR = 1;
   localparam int unsigned PL_MEPC = 2;
   localparam int unsigned PL_SEPC = 3;
   localparam int unsigned PL_TSEL = 4;
   localparam int unsigned NPLAIN  = 5;

   function automatic csr_sel_e csr_decode(input logic [CSR_AW-1:0] a);
      csr_sel_e s;
      case (a)
         A_MSTATUS:  s = SEL_MSTATUS;
         A_SSTATUS:  s = SEL_SSTATUS;
         A_MIDELEG:  s = SEL_MIDELEG;
         A_MIE:      s = SEL_MIE;
         A_SIE:      s = SEL_SIE;
         A_MIP:      s = SEL_MIP;
         A_SIP:      s = SEL_SIP;
         A_MSCRATCH: s = SEL_MSCRATCH;
         A_SSCRATCH: s = SEL_SSCRATCH;
         A_MEPC:     s = SEL_MEPC;
         A_SEPC:     s = SEL_SEPC;
         A_TSEL:     s = SEL_TSEL;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/csr_status_view.sv
module csr_status_view
   import trap_csr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_mach,
   input  logic            we_sup,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] mstatus_o,
   output logic [XLEN-1:0] sstatus_o
);

   localparam logic [XLEN-1:0] WMASK = XLEN'(STATUS_WMASK);
   localparam logic [XLEN-1:0] SMASK = XLEN'(SSTATUS_VIEW);

   if (XLEN < 20) begin : g_bad_xlen
      $error("csr_status_view: XLEN must cover bit 19");
   end

   logic [XLEN-1:0] st_q;
   logic [XLEN-1:0] st_d;
   logic [XLEN-1:0] legal_m;

   always_comb begin
      legal_m = wdata & WMASK;
      // refuse the reserved previous-privilege code, keep the old one
      if (legal_m[MPP_LSB +: 2] == MPP_RESERVED) begin
         legal_m[MPP_LSB +: 2] = st_q[MPP_LSB +: 2];
      end
      st_d = st_q;
      if (we_mach) begin
         st_d = legal_m;
      end else if (we_sup) begin
         st_d = (st_q & ~SMASK) | (wdata & SMASK);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q <= st_d;
      end
   end

   assign mstatus_o = st_q;
   assign sstatus_o = st_q & SMASK;

endmodule

// File: rtl/csr_irq_view.sv
module csr_irq_view #(
   parameter int unsigned     XLEN         = 32,
   parameter logic [XLEN-1:0] DELEG_MASK   = XLEN'(32'h222),
   parameter logic [XLEN-1:0] MIE_MASK     = XLEN'(32'hAAA),
   parameter logic [XLEN-1:0] MIP_SW_MASK  = XLEN'(32'h222),
   parameter logic [XLEN-1:0] HW_PEND_MASK = XLEN'(32'hAAA)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_deleg,
   input  logic            we_mie,
   input  logic            we_sie,
   input  logic            we_mip,
   input  logic            we_sip,
   input  logic [XLEN-1:0] wdata,
   input  logic [XLEN-1:0] hw_pending,
   output logic [XLEN-1:0] mideleg_o,
   output logic [XLEN-1:0] mie_o,
   output logic [XLEN-1:0] sie_o,
   output logic [XLEN-1:0] mip_o,
   output logic [XLEN-1:0] sip_o,
   output logic [XLEN-1:0] mip_sw_o
);

   if ((DELEG_MASK & ~MIE_MASK) != '0) begin : g_bad_deleg
      $error("csr_irq_view: delegable bits must be enable bits");
   end
   if ((MIP_SW_MASK & ~MIE_MASK) != '0) begin : g_bad_swp
      $error("csr_irq_view: software pending bits must be enable bits");
   end
   if ((HW_PEND_MASK & ~MIE_MASK) != '0) begin : g_bad_hwp
      $error("csr_irq_view: hardware pending bits must be enable bits");
   end

   logic [XLEN-1:0] deleg_q;
   logic [XLEN-1:0] ie_q;
   logic [XLEN-1:0] ipsw_q;
   logic [XLEN-1:0] hw_eff;
   logic            unused_hw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deleg_q <= '0;
         ie_q    <= '0;
         ipsw_q  <= '0;
      end else begin
         if (we_deleg) begin
            deleg_q <= wdata & DELEG_MASK;
         end
         if (we_mie) begin
            ie_q <= wdata & MIE_MASK;
         end else if (we_sie) begin
            ie_q <= (ie_q & ~deleg_q) | (wdata & deleg_q);
         end
         if (we_mip) begin
            ipsw_q <= wdata & MIP_SW_MASK;
         end else if (we_sip) begin
            ipsw_q <= (ipsw_q & ~deleg_q) | (wdata & deleg_q & MIP_SW_MASK);
         end
      end
   end

   assign hw_eff    = hw_pending & HW_PEND_MASK;
   assign unused_hw = ^(hw_pending & ~HW_PEND_MASK);

   assign mideleg_o = deleg_q;
   assign mie_o     = ie_q;
   assign sie_o     = ie_q & deleg_q;
   assign mip_o     = ipsw_q | hw_eff;
   assign sip_o     = (ipsw_q | hw_eff) & deleg_q;
   assign mip_sw_o  = ipsw_q;

endmodule

// File: rtl/csr_plain_regs.sv
module csr_plain_regs
   import trap_csr_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned ALIGN_MODE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPLAIN-1:0] we,
   input  logic [XLEN-1:0]   wdata,
   input  logic              compressed_en,
   output logic [XLEN-1:0]   mscratch_o,
   output logic [XLEN-1:0]   sscratch_o,
   output logic [XLEN-1:0]   mepc_o,
   output logic [XLEN-1:0]   sepc_o,
   output logic [XLEN-1:0]   tsel_o
);

   localparam logic [XLEN-1:0] MASK_HALF = ~XLEN'(1);
   localparam logic [XLEN-1:0] MASK_WORD = ~XLEN'(3);

   if (ALIGN_MODE > 2) begin : g_bad_align
      $error("csr_plain_regs: ALIGN_MODE must be 0, 1 or 2");
   end

   logic [XLEN-1:0] store_q [NPLAIN];
   logic [XLEN-1:0] pc_mask;

   for (genvar i = 0; i < NPLAIN; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            store_q[i] <= '0;
         end else if (we[i]) begin
            store_q[i] <= wdata;
         end
      end
   end

   if (ALIGN_MODE == 0) begin : g_align_word
      logic unused_cmp;
      assign unused_cmp = compressed_en;
      assign pc_mask    = MASK_WORD;
   end else if (ALIGN_MODE == 1) begin : g_align_half
      logic unused_cmp;
      assign unused_cmp = compressed_en;
      assign pc_mask    = MASK_HALF;
   end else begin : g_align_runtime
      assign pc_mask = compressed_en ? MASK_HALF : MASK_WORD;
   end

   assign mscratch_o = store_q[PL_MSCR];
   assign sscratch_o = store_q[PL_SSCR];
   assign mepc_o     = store_q[PL_MEPC] & pc_mask;
   assign sepc_o     = store_q[PL_SEPC] & pc_mask;
   assign tsel_o     = ~store_q[PL_TSEL];

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
   import trap_csr_pkg::*;
#(
   parameter int unsigned     XLEN         = 32,
   parameter int unsigned     ALIGN_MODE   = 2,
   parameter logic [XLEN-1:0] DELEG_MASK   = XLEN'(32'h222),
   parameter logic [XLEN-1:0] MIE_MASK     = XLEN'(32'hAAA),
   parameter logic [XLEN-1:0] MIP_SW_MASK  = XLEN'(32'h222),
   parameter logic [XLEN-1:0] HW_PEND_MASK = XLEN'(32'hAAA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr_en,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic              compressed_en,
   input  logic [XLEN-1:0]   hw_pending
);

   if (XLEN < 20) begin : g_bad_xlen
      $error("trap_csr_bank: XLEN below 20 cannot hold the status bits");
   end

   csr_sel_e          sel;
   logic [NSEL-1:0]   we_sel;
   logic [NPLAIN-1:0] we_plain;

   logic [XLEN-1:0] mstatus_v, sstatus_v;
   logic [XLEN-1:0] mideleg_v, mie_v, sie_v, mip_v, sip_v, mip_sw_v;
   logic [XLEN-1:0] mscr_v, sscr_v, mepc_v, sepc_v, tsel_v;

   always_comb begin
      sel    = csr_decode(csr_addr);
      we_sel = '0;
      if (csr_wr_en) begin
         we_sel[sel] = 1'b1;
      end
   end

   assign we_plain[PL_MSCR] = we_sel[SEL_MSCRATCH];
   assign we_plain[PL_SSCR] = we_sel[SEL_SSCRATCH];
   assign we_plain[PL_MEPC] = we_sel[SEL_MEPC];
   assign we_plain[PL_SEPC] = we_sel[SEL_SEPC];
   assign we_plain[PL_TSEL] = we_sel[SEL_TSEL];

   csr_status_view #(.XLEN(XLEN)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_mach   (we_sel[SEL_MSTATUS]),
      .we_sup    (we_sel[SEL_SSTATUS]),
      .wdata     (csr_wdata),
      .mstatus_o (mstatus_v),
      .sstatus_o (sstatus_v)
   );

   csr_irq_view #(
      .XLEN         (XLEN),
      .DELEG_MASK   (DELEG_MASK),
      .MIE_MASK     (MIE_MASK),
      .MIP_SW_MASK  (MIP_SW_MASK),
      .HW_PEND_MASK (HW_PEND_MASK)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_deleg   (we_sel[SEL_MIDELEG]),
      .we_mie     (we_sel[SEL_MIE]),
      .we_sie     (we_sel[SEL_SIE]),
      .we_mip     (we_sel[SEL_MIP]),
      .we_sip     (we_sel[SEL_SIP]),
      .wdata      (csr_wdata),
      .hw_pending (hw_pending),
      .mideleg_o  (mideleg_v),
      .mie_o      (mie_v),
      .sie_o      (sie_v),
      .mip_o      (mip_v),
      .sip_o      (sip_v),
      .mip_sw_o   (mip_sw_v)
   );

   csr_plain_regs #(
      .XLEN       (XLEN),
      .ALIGN_MODE (ALIGN_MODE)
   ) u_plain (
      .clk           (clk),
      .rst_n         (rst_n),
      .we            (we_plain),
      .wdata         (csr_wdata),
      .compressed_en (compressed_en),
      .mscratch_o    (mscr_v),
      .sscratch_o    (sscr_v),
      .mepc_o        (mepc_v),
      .sepc_o        (sepc_v),
      .tsel_o        (tsel_v)
   );

   always_comb begin
      unique case (sel)
         SEL_MSTATUS:  csr_rdata = mstatus_v;
         SEL_SSTATUS:  csr_rdata = sstatus_v;
         SEL_MIDELEG:  csr_rdata = mideleg_v;
         SEL_MIE:      csr_rdata = mie_v;
         SEL_SIE:      csr_rdata = sie_v;
         SEL_MIP:      csr_rdata = mip_v;
         SEL_SIP:      csr_rdata = sip_v;
         SEL_MSCRATCH: csr_rdata = mscr_v;
         SEL_SSCRATCH: csr_rdata = sscr_v;
         SEL_MEPC:     csr_rdata = mepc_v;
         SEL_SEPC:     csr_rdata = sepc_v;
         SEL_TSEL:     csr_rdata = tsel_v;
         default:      csr_rdata = '0;
      endcase
   end

endmodule

// File: rtl/trap_csr_bank_chk.sv
module trap_csr_bank_chk
   import trap_csr_pkg::*;
#(
   parameter int unsigned     XLEN         = 32,
   parameter logic [XLEN-1:0] HW_PEND_MASK = XLEN'(32'hAAA)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_wr_en,
   input logic [CSR_AW-1:0] csr_addr,
   input logic [XLEN-1:0]   csr_wdata,
   input logic [XLEN-1:0]   csr_rdata,
   input logic [XLEN-1:0]   hw_pending,
   input logic [XLEN-1:0]   mstatus_v,
   input logic [XLEN-1:0]   mie_v,
   input logic [XLEN-1:0]   mideleg_v,
   input logic [XLEN-1:0]   mip_sw_v
);

   localparam logic [XLEN-1:0] SMASK = XLEN'(SSTATUS_VIEW);

   logic unmapped;
   assign unmapped = (csr_decode(csr_addr) == SEL_NONE);

   // R2: the reserved previous-mode code never lands in the status word
   assert_mpp_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mstatus_v[MPP_LSB +: 2] != MPP_RESERVED);

   // R3: a supervisor status write leaves machine-only bits alone
   assert_sstatus_keeps_mbits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && csr_addr == A_SSTATUS) |=>
         ((mstatus_v & ~SMASK) == ($past(mstatus_v) & ~SMASK)));

   // R5: supervisor enable write touches only delegated enable bits
   assert_sie_undelegated_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && csr_addr == A_SIE) |=>
         ((mie_v & ~$past(mideleg_v)) == ($past(mie_v) & ~$past(mideleg_v))));

   // R6: a hardware pending bit is always visible in the machine pending read
   assert_hw_pending_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == A_MIP) |->
         ((csr_rdata & hw_pending & HW_PEND_MASK) == (hw_pending & HW_PEND_MASK)));

   // R7: supervisor pending write touches only delegated pending bits
   assert_sip_undelegated_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && csr_addr == A_SIP) |=>
         ((mip_sw_v & ~$past(mideleg_v)) == ($past(mip_sw_v) & ~$past(mideleg_v))));

   // R9: return PCs never read with bit 0 set
   assert_epc_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == A_MEPC || csr_addr == A_SEPC) |-> (csr_rdata[0] == 1'b0));

   // R10: trigger select reads back inverted in the cycle after its write
   assert_tsel_inverted_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && csr_addr == A_TSEL) ##1 (csr_addr == A_TSEL) |->
         (csr_rdata == ~$past(csr_wdata)));

   // R11: unmapped reads are zero
   assert_unmapped_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (csr_rdata == '0));

   // R11: unmapped writes change no shared state
   assert_unmapped_write_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && unmapped) |=>
         ($stable(mstatus_v) && $stable(mie_v) && $stable(mideleg_v) && $stable(mip_sw_v)));

endmodule

bind trap_csr_bank trap_csr_bank_chk #(
   .XLEN         (XLEN),
   .HW_PEND_MASK (HW_PEND_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .csr_wr_en  (csr_wr_en),
   .csr_addr   (csr_addr),
   .csr_wdata  (csr_wdata),
   .csr_rdata  (csr_rdata),
   .hw_pending (hw_pending),
   .mstatus_v  (mstatus_v),
   .mie_v      (mie_v),
   .mideleg_v  (mideleg_v),
   .mip_sw_v   (mip_sw_v)
);

// File: tb/trap_csr_bank_test.sv
`timescale 1ns/1ps
module trap_csr_bank_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        csr_wr_en;
   logic [11:0] csr_addr;
   logic [31:0] csr_wdata;
   logic [31:0] csr_rdata;
   logic        compressed_en;
   logic [31:0] hw_pending;

   always #2.5 clk = ~clk;

   trap_csr_bank uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .csr_wr_en     (csr_wr_en),
      .csr_addr      (csr_addr),
      .csr_wdata     (csr_wdata),
      .csr_rdata     (csr_rdata),
      .compressed_en (compressed_en),
      .hw_pending    (hw_pending)
   );

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;

   localparam logic [11:0] ADDRS [12] = '{12'h300, 12'h100, 12'h303, 12'h304,
                                          12'h104, 12'h344, 12'h144, 12'h340,
                                          12'h140, 12'h341, 12'h141, 12'h7A0};
   localparam logic [31:0] DELEGS [4] = '{32'h0, 32'h222, 32'h200, 32'h022};

   // bench-side model of the architectural state
   logic [31:0] m_st, m_ie, m_dg, m_ip, m_mscr, m_sscr, m_mepc, m_sepc, m_tsel;

   function automatic logic [31:0] pat(int p);
      if (p < 32)  return 32'h1 << p;
      if (p == 32) return 32'hFFFF_FFFF;
      if (p == 33) return 32'h5A5A_5A5A;
      if (p == 34) return 32'h0000_1000;
      return 32'h0;
   endfunction

   function automatic string req_of(logic [11:0] a);
      case (a)
         12'h300:          return "R2";
         12'h100:          return "R3";
         12'h303:          return "R4";
         12'h304, 12'h104: return "R5";
         12'h344:          return "R6";
         12'h144:          return "R7";
         12'h340, 12'h140: return "R8";
         12'h341, 12'h141: return "R9";
         12'h7A0:          return "R10";
         default:          return "R11";
      endcase
   endfunction

   function automatic bit is_impl(logic [11:0] a);
      foreach (ADDRS[i]) if (ADDRS[i] == a) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_rd(logic [11:0] a);
      logic [31:0] pend;
      logic [31:0] pcm;
      pend = m_ip | (hw_pending & 32'hAAA);
      pcm  = compressed_en ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
      case (a)
         12'h300: return m_st;
         12'h100: return m_st & 32'h000C_0122;
         12'h303: return m_dg;
         12'h304: return m_ie;
         12'h104: return m_ie & m_dg;
         12'h344: return pend;
         12'h144: return pend & m_dg;
         12'h340: return m_mscr;
         12'h140: return m_sscr;
         12'h341: return m_mepc & pcm;
         12'h141: return m_sepc & pcm;
         12'h7A0: return ~m_tsel;
         default: return 32'h0;
      endcase
   endfunction

   task automatic mdl_wr(logic [11:0] a, logic [31:0] d);
      logic [31:0] nv;
      case (a)
         12'h300: begin
            nv = d & 32'h000C_19AA;
            if (nv[12:11] == 2'b10) nv[12:11] = m_st[12:11];
            m_st = nv;
         end
         12'h100: m_st = (m_st & ~32'h000C_0122) | (d & 32'h000C_0122);
         12'h303: m_dg = d & 32'h222;
         12'h304: m_ie = d & 32'hAAA;
         12'h104: m_ie = (m_ie & ~m_dg) | (d & m_dg);
         12'h344: m_ip = d & 32'h222;
         12'h144: m_ip = (m_ip & ~m_dg) | (d & m_dg & 32'h222);
         12'h340: m_mscr = d;
         12'h140: m_sscr = d;
         12'h341: m_mepc = d;
         12'h141: m_sepc = d;
         12'h7A0: m_tsel = d;
         default: ;
      endcase
   endtask

   task automatic chk(string r, logic [11:0] a, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%03h actual=%08h expected=%08h", r, a, act, exp);
      end
   endtask

   task automatic do_wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      csr_wr_en = 1'b1;
      csr_addr  = a;
      csr_wdata = d;
      @(negedge clk);
      csr_wr_en = 1'b0;
      mdl_wr(a, d);
   endtask

   task automatic rd_chk(logic [11:0] a, string r);
      @(negedge clk);
      csr_addr = a;
      #1;
      chk(r, a, csr_rdata, exp_rd(a));
   endtask

   // full readback; tag "" means each address reports its own requirement
   task automatic check_all(string tag);
      foreach (ADDRS[i]) rd_chk(ADDRS[i], (tag == "") ? req_of(ADDRS[i]) : tag);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired before the run completed");
      finish_run();
   end

   initial begin
      rst_n         = 1'b0;
      csr_wr_en     = 1'b0;
      csr_addr      = 12'h0;
      csr_wdata     = 32'h0;
      compressed_en = 1'b0;
      hw_pending    = 32'h0;
      {m_st, m_ie, m_dg, m_ip, m_mscr, m_sscr, m_mepc, m_sepc, m_tsel} = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values, trigger select reads all ones
      check_all("R1");

      // R2..R10: pattern sweep under each delegation setting and pin mode
      foreach (DELEGS[di]) begin
         for (int md = 0; md < 2; md++) begin
            @(negedge clk);
            hw_pending    = md ? 32'hFFFF_FFFF : 32'h0;
            compressed_en = md[0];
            foreach (ADDRS[ai]) begin
               if (ADDRS[ai] == 12'h104 || ADDRS[ai] == 12'h144)
                  do_wr(12'h303, DELEGS[di]);
               for (int p = 0; p < 36; p++) begin
                  do_wr(ADDRS[ai], pat(p));
                  check_all("");
               end
            end
         end
      end

      // R6: software clear cannot drop a hardware-held pending bit
      @(negedge clk);
      hw_pending = 32'h0000_0800;
      do_wr(12'h344, 32'hFFFF_FFFF);
      do_wr(12'h344, 32'h0);
      rd_chk(12'h344, "R6");
      @(negedge clk);
      hw_pending = 32'h0;
      rd_chk(12'h344, "R6");

      // R9: read mask follows the compressed-enable pin with no write
      do_wr(12'h341, 32'h8000_0007);
      do_wr(12'h141, 32'h0000_0003);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         compressed_en = c[0];
         rd_chk(12'h341, "R9");
         rd_chk(12'h141, "R9");
      end

      // R11: reads of every unimplemented address return zero
      for (int a = 0; a < 4096; a++) begin
         if (!is_impl(12'(a))) rd_chk(12'(a), "R11");
      end

      // R11: writes to unimplemented addresses leave the whole bank intact
      do_wr(12'h303, 32'h222);
      do_wr(12'h304, 32'h0A0A);
      do_wr(12'h340, 32'h1234_5678);
      do_wr(12'h301, 32'hFFFF_FFFF);
      do_wr(12'h105, 32'hFFFF_FFFF);
      do_wr(12'h7A1, 32'hFFFF_FFFF);
      do_wr(12'hF14, 32'hFFFF_FFFF);
      do_wr(12'h342, 32'hFFFF_FFFF);
      check_all("R11");

      finish_run();
   end

endmodule